// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (clock and open-drain data). It holds three configuration registers: a 16-bit mode word, a 16-bit divider word and an 8-bit bus word. Both bus lines are oversampled by the faster system clock. The block detects START, STOP and repeated START. It matches a 7-bit address, acknowledges bytes, accepts register writes and returns register contents on reads.

A write transaction carries the address byte, then a command byte, then data bytes. The command byte selects a register or asks for a store. The two 16-bit registers travel high byte first. Storing to nonvolatile memory is modelled as a timer. Starting a store raises a one-cycle pulse and holds a busy flag for a fixed number of clocks, and the slave refuses every byte while busy. A write-control bit in the bus word selects one of two store policies. With automatic storing, a store starts after each register write. With commanded storing, a store starts only on an explicit command. Writing the bus word always stores at once. While the external power-down input is high, the registers are frozen.

Top module: `cfgbus_slave`

## Requirements
- R1: After reset, mode_word is 0x1800, div_word and bus_word are 0x0000 and 0x00, store_busy and store_pulse are low, and sda_oe is low.
- R2: An address byte is 1011 in bits 7..4, bus_word[2:0] in bits 3..1, and a direction bit in bit 0 (1 = read, 0 = write). On a match the slave pulls SDA low during the ninth clock. Any other address gets no acknowledge, and the slave ignores the bus until the next START.
- R3: In a write, the first byte after the address is a command: 0x02 selects the mode word, 0x01 the divider word, 0x0D the bus word, and 0x3F asks for a store. The bytes that follow fill the selected register high byte first. Data bytes after an unknown command are acknowledged but change nothing.
- R4: A read returns the register chosen by the last command, starting from its high byte. Bytes past the register's length, and every byte of an unknown command, read 0x00. The transfer ends when the master does not acknowledge.
- R5: Bit 15 and bits 5..0 of mode_word, bits 5..0 of div_word and bits 7..4 of bus_word always read 0, whatever is written.
- R6: When bus_word bit 3 (write control) is 0, a STOP that ends a transaction which wrote the mode or divider word starts a store.
- R7: When bus_word bit 3 is 1, a STOP starts no store. The command 0x3F starts a store under either setting.
- R8: Writing the bus word starts a store as soon as that data byte is accepted, before any STOP, whatever the write-control setting.
- R9: A store raises store_pulse for exactly one clock. store_busy rises in the same clock and stays high for exactly STORE_CYCLES clocks. A new store never begins while one is in progress.
- R10: While store_busy is high, the slave acknowledges no byte, neither an address nor data.
- R11: While pwrdn_i is high, data bytes and the store command are acknowledged but ignored: the registers keep their values and no store starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| pwrdn_i | input | 1 | Power-down state; freezes the registers |
| sda_oe | output | 1 | When high, the data line is pulled low |
| mode_word | output | 16 | Mode register |
| div_word | output | 16 | Divider register, divisor field in bits 15..6 |
| bus_word | output | 8 | Bus register: bit 3 write control, bits 2..0 address |
| store_pulse | output | 1 | One-clock strobe that starts a store |
| store_busy | output | 1 | High while the modelled store is in progress |

## Verification
The checker watches on every cycle that the reserved bits stay zero and that the registers hold still while power-down is active. It also checks that a store pulse opens a busy window only when none is already running, and that the slave never begins pulling the data line low while a store is in progress. The bench scenarios are the only place to see protocol behaviour that spans many bytes. That covers address matching against a reprogrammed bus word, the choice of store trigger under each write-control setting, the exact busy length, and read-back of each register including bytes past its end.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [3:0]  DEV_CODE  = 4'b1011;

    localparam logic [7:0]  CMD_MODE  = 8'h02;
    localparam logic [7:0]  CMD_DIV   = 8'h01;
    localparam logic [7:0]  CMD_BUS   = 8'h0D;
    localparam logic [7:0]  CMD_STORE = 8'h3F;

    localparam logic [15:0] MODE_MASK  = 16'h7FC0;
    localparam logic [15:0] DIV_MASK   = 16'hFFC0;
    localparam logic [7:0]  BUS_MASK   = 8'h0F;
    localparam logic [15:0] MODE_RESET = 16'h1800;

    localparam int WC_BIT = 3;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_RX,
        LK_RX_ACK,
        LK_TX,
        LK_TX_ACK
    } link_state_e;

endpackage

// File: rtl/cfgbus_sampler.sv
module cfgbus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    localparam smp_t SMP_RESET = '{
        scl_sync: '1,
        sda_sync: '1,
        scl_prev: 1'b1,
        sda_prev: 1'b1
    };

    smp_t smp_d, smp_q;
    logic scl_s;

    assign scl_s = smp_q.scl_sync[LAST];
    assign sda_s = smp_q.sda_sync[LAST];

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sync = {smp_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_sync = {smp_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = scl_s;
        smp_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= SMP_RESET;
        else        smp_q <= smp_d;
    end

    assign scl_rise  = scl_s & ~smp_q.scl_prev;
    assign scl_fall  = ~scl_s & smp_q.scl_prev;
    assign start_evt = scl_s & smp_q.scl_prev & smp_q.sda_prev & ~sda_s;
    assign stop_evt  = scl_s & smp_q.scl_prev & ~smp_q.sda_prev & sda_s;

endmodule

// File: rtl/cfgbus_link.sv
module cfgbus_link
    import cfgbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic [2:0]        dev_sel,
    input  logic              busy,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              addr_ok,
    output logic              addr_rd,
    output logic              tx_take
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        link_state_e       state;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              rd;
        logic              drive;
        logic              mack;
    } lnk_t;

    localparam lnk_t LNK_RESET = '{
        state:  LK_IDLE,
        bitcnt: '0,
        shreg:  '0,
        rd:     1'b0,
        drive:  1'b0,
        mack:   1'b0
    };

    lnk_t lnk_d, lnk_q;
    logic addr_hit;

    assign addr_hit = (lnk_q.shreg[7:4] == DEV_CODE) &&
                      (lnk_q.shreg[3:1] == dev_sel) && !busy;

    always_comb begin
        lnk_d    = lnk_q;
        rx_valid = 1'b0;
        addr_ok  = 1'b0;
        tx_take  = 1'b0;
        if (start_evt) begin
            lnk_d.state  = LK_ADDR;
            lnk_d.bitcnt = '0;
            lnk_d.drive  = 1'b0;
        end else if (stop_evt) begin
            lnk_d.state = LK_IDLE;
            lnk_d.drive = 1'b0;
        end else begin
            unique case (lnk_q.state)
                LK_ADDR, LK_RX: begin
                    if (scl_rise && lnk_q.bitcnt != FULL) begin
                        lnk_d.shreg  = {lnk_q.shreg[BYTE_W-2:0], sda_s};
                        lnk_d.bitcnt = lnk_q.bitcnt + 1'b1;
                    end else if (scl_fall && lnk_q.bitcnt == FULL) begin
                        if (lnk_q.state == LK_ADDR) begin
                            if (addr_hit) begin
                                lnk_d.drive = 1'b1;
                                lnk_d.rd    = lnk_q.shreg[0];
                                lnk_d.state = LK_ADDR_ACK;
                                addr_ok     = 1'b1;
                            end else begin
                                lnk_d.state = LK_IDLE;
                            end
                        end else begin
                            if (!busy) begin
                                lnk_d.drive = 1'b1;
                                lnk_d.state = LK_RX_ACK;
                                rx_valid    = 1'b1;
                            end else begin
                                lnk_d.state = LK_IDLE;
                            end
                        end
                    end
                end
                LK_ADDR_ACK: begin
                    if (scl_fall) begin
                        lnk_d.bitcnt = '0;
                        if (lnk_q.rd) begin
                            lnk_d.state = LK_TX;
                            lnk_d.shreg = tx_byte;
                            lnk_d.drive = ~tx_byte[BYTE_W-1];
                            tx_take     = 1'b1;
                        end else begin
                            lnk_d.state = LK_RX;
                            lnk_d.drive = 1'b0;
                        end
                    end
                end
                LK_RX_ACK: begin
                    if (scl_fall) begin
                        lnk_d.drive  = 1'b0;
                        lnk_d.bitcnt = '0;
                        lnk_d.state  = LK_RX;
                    end
                end
                LK_TX: begin
                    if (scl_fall) begin
                        if (lnk_q.bitcnt == LAST) begin
                            lnk_d.drive = 1'b0;
                            lnk_d.state = LK_TX_ACK;
                        end else begin
                            lnk_d.bitcnt = lnk_q.bitcnt + 1'b1;
                            lnk_d.shreg  = {lnk_q.shreg[BYTE_W-2:0], 1'b0};
                            lnk_d.drive  = ~lnk_q.shreg[BYTE_W-2];
                        end
                    end
                end
                LK_TX_ACK: begin
                    if (scl_rise) begin
                        lnk_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (lnk_q.mack) begin
                            lnk_d.state  = LK_TX;
                            lnk_d.bitcnt = '0;
                            lnk_d.shreg  = tx_byte;
                            lnk_d.drive  = ~tx_byte[BYTE_W-1];
                            tx_take      = 1'b1;
                        end else begin
                            lnk_d.state = LK_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lnk_q <= LNK_RESET;
        else        lnk_q <= lnk_d;
    end

    assign sda_oe  = lnk_q.drive;
    assign rx_data = lnk_q.shreg;
    assign addr_rd = lnk_q.shreg[0];

endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
    import cfgbus_pkg::*;
#(
    parameter int STORE_CYCLES = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_i,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              addr_ok,
    input  logic              addr_rd,
    input  logic              tx_take,
    input  logic              bus_stop,
    output logic [15:0]       mode_word,
    output logic [15:0]       div_word,
    output logic [7:0]        bus_word,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              store_pulse,
    output logic              store_busy
);

    localparam int TW = $clog2(STORE_CYCLES + 1);
    localparam logic [TW-1:0] TLOAD = TW'(STORE_CYCLES);

    typedef struct packed {
        logic [15:0]       mode;
        logic [15:0]       div;
        logic [7:0]        bus;
        logic [BYTE_W-1:0] cmd;
        logic              have_cmd;
        logic [1:0]        idx;
        logic              dirty;
        logic [TW-1:0]     timer;
        logic              pulse;
    } reg_t;

    localparam reg_t REG_RESET = '{
        mode:     MODE_RESET,
        div:      '0,
        bus:      '0,
        cmd:      CMD_MODE,
        have_cmd: 1'b0,
        idx:      '0,
        dirty:    1'b0,
        timer:    '0,
        pulse:    1'b0
    };

    reg_t reg_d, reg_q;
    logic start;
    logic idle;

    assign idle = (reg_q.timer == '0);

    always_comb begin
        reg_d = reg_q;
        start = 1'b0;
        if (addr_ok) begin
            reg_d.idx = '0;
            if (!addr_rd) reg_d.have_cmd = 1'b0;
        end
        if (rx_valid) begin
            if (!reg_q.have_cmd) begin
                reg_d.cmd      = rx_data;
                reg_d.have_cmd = 1'b1;
                reg_d.idx      = '0;
                if (rx_data == CMD_STORE && !pwrdn_i) start = 1'b1;
            end else begin
                if (!pwrdn_i) begin
                    unique case (reg_q.cmd)
                        CMD_MODE: begin
                            if (reg_q.idx == 2'd0) begin
                                reg_d.mode[15:8] = rx_data & MODE_MASK[15:8];
                                reg_d.dirty      = 1'b1;
                            end else if (reg_q.idx == 2'd1) begin
                                reg_d.mode[7:0] = rx_data & MODE_MASK[7:0];
                                reg_d.dirty     = 1'b1;
                            end
                        end
                        CMD_DIV: begin
                            if (reg_q.idx == 2'd0) begin
                                reg_d.div[15:8] = rx_data & DIV_MASK[15:8];
                                reg_d.dirty     = 1'b1;
                            end else if (reg_q.idx == 2'd1) begin
                                reg_d.div[7:0] = rx_data & DIV_MASK[7:0];
                                reg_d.dirty    = 1'b1;
                            end
                        end
                        CMD_BUS: begin
                            if (reg_q.idx == 2'd0) begin
                                reg_d.bus   = rx_data & BUS_MASK;
                                reg_d.dirty = 1'b0;
                                start       = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (reg_q.idx != 2'd3) reg_d.idx = reg_q.idx + 2'd1;
            end
        end
        if (tx_take && reg_q.idx != 2'd3) reg_d.idx = reg_q.idx + 2'd1;
        if (bus_stop) begin
            if (reg_q.dirty && !reg_d.bus[WC_BIT]) start = 1'b1;
            reg_d.dirty = 1'b0;
        end
        reg_d.pulse = start && idle;
        if (reg_d.pulse)  reg_d.timer = TLOAD;
        else if (!idle)   reg_d.timer = reg_q.timer - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= REG_RESET;
        else        reg_q <= reg_d;
    end

    always_comb begin
        tx_byte = '0;
        unique case (reg_q.cmd)
            CMD_MODE: begin
                if (reg_q.idx == 2'd0)      tx_byte = reg_q.mode[15:8];
                else if (reg_q.idx == 2'd1) tx_byte = reg_q.mode[7:0];
            end
            CMD_DIV: begin
                if (reg_q.idx == 2'd0)      tx_byte = reg_q.div[15:8];
                else if (reg_q.idx == 2'd1) tx_byte = reg_q.div[7:0];
            end
            CMD_BUS: begin
                if (reg_q.idx == 2'd0)      tx_byte = reg_q.bus;
            end
            default: ;
        endcase
    end

    assign mode_word   = reg_q.mode;
    assign div_word    = reg_q.div;
    assign bus_word    = reg_q.bus;
    assign store_pulse = reg_q.pulse;
    assign store_busy  = !idle;

endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
    import cfgbus_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int STORE_CYCLES = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        pwrdn_i,
    output logic        sda_oe,
    output logic [15:0] mode_word,
    output logic [15:0] div_word,
    output logic [7:0]  bus_word,
    output logic        store_pulse,
    output logic        store_busy
);

    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              rx_valid, addr_ok, addr_rd, tx_take;
    logic [BYTE_W-1:0] rx_data, tx_byte;

    cfgbus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    cfgbus_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s),
        .dev_sel   (bus_word[2:0]),
        .busy      (store_busy),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .addr_ok   (addr_ok),
        .addr_rd   (addr_rd),
        .tx_take   (tx_take)
    );

    cfgbus_regs #(.STORE_CYCLES(STORE_CYCLES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwrdn_i     (pwrdn_i),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .addr_ok     (addr_ok),
        .addr_rd     (addr_rd),
        .tx_take     (tx_take),
        .bus_stop    (stop_evt),
        .mode_word   (mode_word),
        .div_word    (div_word),
        .bus_word    (bus_word),
        .tx_byte     (tx_byte),
        .store_pulse (store_pulse),
        .store_busy  (store_busy)
    );

endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pwrdn_i,
    input logic        sda_oe,
    input logic [15:0] mode_word,
    input logic [15:0] div_word,
    input logic [7:0]  bus_word,
    input logic        store_pulse,
    input logic        store_busy
);

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_word[15] == 1'b0) && (mode_word[5:0] == 6'd0) &&
        (div_word[5:0] == 6'd0) && (bus_word[7:4] == 4'd0));

    // R11
    pwrdn_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwrdn_i) |-> ($stable(mode_word) && $stable(div_word) &&
                            $stable(bus_word) && !store_pulse));

    // R9
    pulse_opens_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |-> (store_busy && !$past(store_busy)));

    // R9
    busy_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_busy) |-> store_pulse);

    // R10
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(store_busy));

endmodule

bind cfgbus_slave cfgbus_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwrdn_i     (pwrdn_i),
    .sda_oe      (sda_oe),
    .mode_word   (mode_word),
    .div_word    (div_word),
    .bus_word    (bus_word),
    .store_pulse (store_pulse),
    .store_busy  (store_busy)
);

// File: tb/cfgbus_slave_bench.sv
`timescale 1ns/1ps
module cfgbus_slave_bench;

    localparam int Q      = 10;
    localparam int STORE  = 1500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        pwrdn = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [15:0] mode_word, div_word;
    logic [7:0]  bus_word;
    logic        store_pulse, store_busy;

    int n_chk = 0;
    int n_fail = 0;
    int n_store = 0;
    int run_len = 0;
    int last_len = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    cfgbus_slave #(.SYNC_STAGES(2), .STORE_CYCLES(STORE)) u_cfgbus_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .pwrdn_i     (pwrdn),
        .sda_oe      (sda_oe),
        .mode_word   (mode_word),
        .div_word    (div_word),
        .bus_word    (bus_word),
        .store_pulse (store_pulse),
        .store_busy  (store_busy)
    );

    always @(negedge clk) begin
        if (store_pulse) n_store++;
        if (store_busy) run_len++;
        else if (run_len != 0) begin
            last_len = run_len;
            run_len  = 0;
        end
    end

    // cmd, d0, d1, expected high byte, expected low byte
    localparam logic [39:0] VEC [0:5] = '{
        40'h02_FF_FF_7F_C0,
        40'h01_AB_CD_AB_C0,
        40'h02_12_34_12_00,
        40'h01_00_3F_00_00,
        40'h0D_F0_00_00_00,
        40'h55_77_88_00_00
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold();
            scl_m = 1'b1; hold(); hold();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        ack = (sda_line == 1'b0);
        hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hold();
            scl_m = 1'b1; hold();
            b = {b[6:0], sda_line};
            hold();
            scl_m = 1'b0;
        end
        sda_m = ~mack; hold();
        scl_m = 1'b1; hold(); hold();
        scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    task automatic write_tx(input logic [2:0] a, input logic [7:0] c,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input int n, output logic ok);
        logic k;
        ok = 1'b1;
        do_start();
        send_byte({4'b1011, a, 1'b0}, k);
        ok &= k;
        if (k) begin
            send_byte(c, k); ok &= k;
            if (n > 0 && k) begin send_byte(b0, k); ok &= k; end
            if (n > 1 && k) begin send_byte(b1, k); ok &= k; end
        end
        do_stop();
    endtask

    task automatic read_tx(input logic [2:0] a, input logic [7:0] c, input int n,
                           output logic [7:0] r0, output logic [7:0] r1,
                           output logic [7:0] r2, output logic ok);
        logic k;
        logic [7:0] r [3];
        r = '{8'h00, 8'h00, 8'h00};
        ok = 1'b1;
        do_start();
        send_byte({4'b1011, a, 1'b0}, k); ok &= k;
        send_byte(c, k); ok &= k;
        do_start();
        send_byte({4'b1011, a, 1'b1}, k); ok &= k;
        if (ok) begin
            for (int i = 0; i < n; i++) recv_byte(i < n - 1, r[i]);
        end
        do_stop();
        r0 = r[0]; r1 = r[1]; r2 = r[2];
    endtask

    task automatic wait_idle();
        while (store_busy) @(negedge clk);
        hold();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements act=timeout exp=completion");
        finish_run();
    end

    initial begin
        logic ok, k1, k2;
        logic [7:0] r0, r1, r2;
        int s0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state at the ports
        check("R1 mode", {16'h0, mode_word}, 32'h1800);
        check("R1 div", {16'h0, div_word}, 32'h0);
        check("R1 bus", {24'h0, bus_word}, 32'h0);
        check("R1 busy/pulse/oe", {29'h0, store_busy, store_pulse, sda_oe}, 32'h0);

        // R4: read mode with one byte past its end
        read_tx(3'd0, 8'h02, 3, r0, r1, r2, ok);
        check("R4 read ack", {31'h0, ok}, 32'h1);
        check("R4 mode bytes", {8'h0, r0, r1, r2}, 32'h00180000);

        // R2: wrong code and wrong select get no acknowledge
        do_start(); send_byte(8'hA0, k1); do_stop();
        check("R2 wrong code nack", {31'h0, k1}, 32'h0);
        write_tx(3'd1, 8'h02, 8'h00, 8'h00, 2, ok);
        check("R2 wrong select nack", {31'h0, ok}, 32'h0);

        // R3 R4 R5: vector table
        for (int v = 0; v < 6; v++) begin
            logic [39:0] e;
            e = VEC[v];
            write_tx(3'd0, e[39:32], e[31:24], e[23:16],
                     (e[39:32] == 8'h0D) ? 1 : 2, ok);
            check("R3 write ack", {31'h0, ok}, 32'h1);
            wait_idle();
            read_tx(3'd0, e[39:32], 2, r0, r1, r2, ok);
            check("R4 R5 readback", {15'h0, ok, r0, r1}, {15'h0, 1'b1, e[15:8], e[7:0]});
        end
        check("R5 mode port", {16'h0, mode_word}, 32'h1200);

        // R6 R9 R10: automatic store after STOP
        s0 = n_store;
        write_tx(3'd0, 8'h02, 8'hAA, 8'h55, 2, ok);
        check("R6 store after stop", n_store - s0, 1);
        check("R6 busy after stop", {31'h0, store_busy}, 32'h1);
        do_start(); send_byte(8'hB0, k1); do_stop();
        check("R10 address nack while busy", {31'h0, k1}, 32'h0);
        wait_idle();
        check("R9 busy length", last_len, STORE);
        check("R5 mode masked", {16'h0, mode_word}, 32'h2A40);

        // R8 R10: bus write stores at once, next byte refused
        s0 = n_store;
        do_start();
        send_byte(8'hB0, k1);
        send_byte(8'h0D, k1);
        send_byte(8'h0B, k1);
        check("R8 store before stop", n_store - s0, 1);
        send_byte(8'h00, k2);
        do_stop();
        check("R8 bus byte ack", {31'h0, k1}, 32'h1);
        check("R10 data nack while busy", {31'h0, k2}, 32'h0);
        check("R8 bus value", {24'h0, bus_word}, 32'h0B);
        check("R8 single store", n_store - s0, 1);
        wait_idle();

        // R2: select now 011
        write_tx(3'd0, 8'h01, 8'h11, 8'h22, 2, ok);
        check("R2 old select nack", {31'h0, ok}, 32'h0);

        // R7: commanded storing
        s0 = n_store;
        write_tx(3'd3, 8'h01, 8'h80, 8'h7F, 2, ok);
        check("R7 write ack", {31'h0, ok}, 32'h1);
        check("R7 no store on stop", n_store - s0, 0);
        check("R7 div value", {16'h0, div_word}, 32'h8040);
        write_tx(3'd3, 8'h3F, 8'h00, 8'h00, 0, ok);
        check("R7 store command", n_store - s0, 1);
        wait_idle();
        read_tx(3'd3, 8'h01, 2, r0, r1, r2, ok);
        check("R4 div readback", {15'h0, ok, r0, r1}, {15'h0, 1'b1, 16'h8040});

        // R11: power-down freezes registers
        pwrdn = 1'b1;
        s0 = n_store;
        write_tx(3'd3, 8'h02, 8'h7F, 8'hC0, 2, ok);
        check("R11 bytes acked", {31'h0, ok}, 32'h1);
        check("R11 mode unchanged", {16'h0, mode_word}, 32'h2A40);
        write_tx(3'd3, 8'h3F, 8'h00, 8'h00, 0, ok);
        write_tx(3'd3, 8'h0D, 8'h00, 8'h00, 1, ok);
        check("R11 bus unchanged", {24'h0, bus_word}, 32'h0B);
        check("R11 no store", n_store - s0, 0);
        pwrdn = 1'b0;
        hold();

        finish_run();
    end

endmodule